// File: doc/BRIEF.md
# BCD Calendar Validator and Codec

This block sits between software-visible binary time fields and a real-time clock chip that keeps its calendar in packed BCD with a two-digit year. The encode path takes a full binary year, month (1 to 12), day, hour, minute and second. It checks them against the supported 1970 to 2069 window, the per-month day limits with the Gregorian leap-year rule, and the 24-hour and 60-minute and 60-second limits. Legal input produces six BCD bytes ready to be shifted out to the clock chip. Illegal input raises an error pulse, and the previously encoded bytes stay in place.

The decode path takes the six BCD bytes read back from the chip and returns binary fields. The year comes back as years since 1900, with the lost century restored from the two-digit value. The month comes back zero-based. A byte holding a nibble above 9 is flagged as an error, and the last good decoded values are kept.

Both paths are registered. A strobe sampled on a rising edge yields its result, plus a one-cycle done or error pulse, right after that edge. The two paths run independently and may be strobed in the same cycle.

Top module: `cal_bcd_codec`

## Requirements
- R1: An encode request whose year lies outside 1970..2069 inclusive is rejected.
- R2: February allows 29 days when the year is divisible by 400, or divisible by 4 but not by 100; otherwise it allows 28 days.
- R3: An encode request is rejected if the month is 0 or above 12, if the day is 0, or if the day exceeds the month limit. The limit is 30 for April, June, September and November, 31 for the other months except February, and the R2 value for February.
- R4: An encode request is rejected if the hour is 24 or more, or if the minute or the second is 60 or more.
- R5: An accepted request writes each field as two BCD digits, with the tens in bits 7:4 and the units in bits 3:0. The year byte holds year-2000 for years from 2000 on, and year-1900 for earlier years.
- R6: A strobe sampled on a rising edge updates the outputs at that edge. The matching done or error flag is high for exactly that one cycle, the two flags are never high together, and both flags are low when no strobe was sampled. The encode and decode paths work independently, also when strobed in the same cycle.
- R7: When an encode request is rejected, the six BCD output bytes keep their previous values.
- R8: Decoding turns each BCD byte into 10*tens+units. The decoded year is the stored value plus 100 when the stored value is 69 or less, and the stored value itself otherwise.
- R9: The decoded month is the binary month minus one, taken modulo 128, so a stored month of 00 yields 127.
- R10: A decode request in which any nibble of the six bytes exceeds 9 raises the decode error flag, and the decoded outputs keep their previous values.
- R11: While reset is high, all data outputs and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid | input | 1 | Encode strobe |
| year_in | input | 12 | Binary full year |
| month_in | input | 4 | Binary month, 1 to 12 |
| day_in | input | 5 | Binary day of month |
| hour_in | input | 5 | Binary hour |
| min_in | input | 6 | Binary minute |
| sec_in | input | 6 | Binary second |
| enc_done | output | 1 | Encode accepted pulse |
| enc_err | output | 1 | Encode rejected pulse |
| bcd_year | output | 8 | Two-digit year, BCD |
| bcd_mon | output | 8 | Month, BCD |
| bcd_day | output | 8 | Day, BCD |
| bcd_hour | output | 8 | Hour, BCD |
| bcd_min | output | 8 | Minute, BCD |
| bcd_sec | output | 8 | Second, BCD |
| dec_valid | input | 1 | Decode strobe |
| rb_year | input | 8 | Stored year byte |
| rb_mon | input | 8 | Stored month byte |
| rb_day | input | 8 | Stored day byte |
| rb_hour | input | 8 | Stored hour byte |
| rb_min | input | 8 | Stored minute byte |
| rb_sec | input | 8 | Stored second byte |
| dec_done | output | 1 | Decode accepted pulse |
| dec_err | output | 1 | Decode rejected pulse |
| dec_year | output | 8 | Years since 1900 |
| dec_mon | output | 7 | Zero-based month |
| dec_day | output | 7 | Binary day |
| dec_hour | output | 7 | Binary hour |
| dec_min | output | 7 | Binary minute |
| dec_sec | output | 7 | Binary second |

## Verification
The bench sweeps every year of the window plus a few years on each side, against every month from 0 to 13 and every day from 0 to 31. This catches an off-by-one window edge, a leap rule that skips the 2000 case, or a 30/31 mix-up, each of which would accept or refuse a single date wrongly. Hours, minutes and seconds are swept past their limits, where a bad comparison would let 24:00 or :60 through. Every decode byte position is driven with all 256 values. A wrong century pivot would misplace stored 69 or 70, and a missed nibble check would turn bytes like 0x3A into garbage binary instead of an error. After each rejected request the bench confirms that the earlier outputs survived; a design that latched on error would overwrite them.

// File: rtl/cal_bcd_pkg.sv
package cal_bcd_pkg;

  localparam int NFIELD = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  // binary 0..99 to packed two-digit BCD
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  // packed two-digit BCD to binary (meaningful only when both digits legal)
  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
  endfunction

  function automatic logic bcd_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic is_leap(input logic [15:0] y);
    return (((y % 16'd4) == 16'd0) && ((y % 16'd100) != 16'd0)) ||
           ((y % 16'd400) == 16'd0);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic lp);
    case (m)
      4'd2:                      return lp ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      4'd1, 4'd3, 4'd5, 4'd7,
      4'd8, 4'd10, 4'd12:        return 5'd31;
      default:                   return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/cal_date_check.sv
module cal_date_check
  import cal_bcd_pkg::*;
#(
  parameter int YEAR_W  = 12,
  parameter int YEAR_LO = 1970,
  parameter int YEAR_HI = 2069
) (
  input  logic [YEAR_W-1:0] year,
  input  logic [3:0]        month,
  input  logic [4:0]        day,
  input  logic [4:0]        hour,
  input  logic [5:0]        minute,
  input  logic [5:0]        second,
  output logic              ok
);

  localparam logic [YEAR_W-1:0] LO_V = YEAR_W'(YEAR_LO);
  localparam logic [YEAR_W-1:0] HI_V = YEAR_W'(YEAR_HI);

  logic       leap;
  logic [4:0] limit;
  logic       year_ok, date_ok, time_ok;

  always_comb begin
    leap    = is_leap(16'(year));
    limit   = month_days(month, leap);
    year_ok = (year >= LO_V) && (year <= HI_V);
    // month 0 and 13..15 give a zero limit, so any day fails
    date_ok = (day != 5'd0) && (day <= limit);
    time_ok = (hour < 5'd24) && (minute < 6'd60) && (second < 6'd60);
    ok      = year_ok && date_ok && time_ok;
  end

endmodule

// File: rtl/cal_bcd_enc.sv
module cal_bcd_enc
  import cal_bcd_pkg::*;
#(
  parameter int YEAR_W       = 12,
  parameter int BASE_CENTURY = 1900
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid,
  input  logic                   ok,
  input  logic [YEAR_W-1:0]      year,
  input  logic [3:0]             month,
  input  logic [4:0]             day,
  input  logic [4:0]             hour,
  input  logic [5:0]             minute,
  input  logic [5:0]             second,
  output logic                   done,
  output logic                   err,
  output logic [NFIELD-1:0][7:0] bcd_q
);

  localparam logic [YEAR_W-1:0] BASE_V = YEAR_W'(BASE_CENTURY);
  localparam logic [YEAR_W-1:0] HUND_V = YEAR_W'(100);

  logic [YEAR_W-1:0]      yrel;
  logic [NFIELD-1:0][6:0] bin;
  logic [NFIELD-1:0][7:0] bcd_d;

  assign yrel         = year - BASE_V;
  assign bin[F_YEAR]  = 7'((yrel >= HUND_V) ? (yrel - HUND_V) : yrel);
  assign bin[F_MON]   = 7'(month);
  assign bin[F_DAY]   = 7'(day);
  assign bin[F_HOUR]  = 7'(hour);
  assign bin[F_MIN]   = 7'(minute);
  assign bin[F_SEC]   = 7'(second);

  for (genvar i = 0; i < NFIELD; i++) begin : g_conv
    assign bcd_d[i] = to_bcd(bin[i]);

    AST_ENC_DIGITS: assert property (@(posedge clk) disable iff (rst)
      done |-> (bcd_q[i][7:4] <= 4'd9 && bcd_q[i][3:0] <= 4'd9)); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      err   <= 1'b0;
      bcd_q <= '0;
    end else begin
      done <= valid && ok;
      err  <= valid && !ok;
      if (valid && ok) bcd_q <= bcd_d;
    end
  end

  AST_ENC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R6
  AST_ENC_STROBE: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> $past(valid)); // R6
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(bcd_q)); // R7

endmodule

// File: rtl/cal_bcd_dec.sv
module cal_bcd_dec
  import cal_bcd_pkg::*;
#(
  parameter int SPLIT = 70
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid,
  input  logic [NFIELD-1:0][7:0] raw,
  output logic                   done,
  output logic                   err,
  output logic [7:0]             year_q,
  output logic [6:0]             mon_q,
  output logic [3:0][6:0]        bin_q
);

  localparam logic [6:0] SPLIT_V = 7'(SPLIT);
  localparam logic [7:0] YMIN_V  = 8'(SPLIT);
  localparam logic [7:0] YMAX_V  = 8'(SPLIT + 99);

  logic [NFIELD-1:0]      dig_ok;
  logic [NFIELD-1:0][6:0] b;
  logic                   all_ok;
  logic [7:0]             yr_d;

  for (genvar i = 0; i < NFIELD; i++) begin : g_dig
    assign dig_ok[i] = bcd_ok(raw[i]);
    assign b[i]      = from_bcd(raw[i]);
  end

  assign all_ok = &dig_ok;
  assign yr_d   = (b[F_YEAR] < SPLIT_V) ? ({1'b0, b[F_YEAR]} + 8'd100)
                                        : {1'b0, b[F_YEAR]};

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      err    <= 1'b0;
      year_q <= '0;
      mon_q  <= '0;
      bin_q  <= '0;
    end else begin
      done <= valid && all_ok;
      err  <= valid && !all_ok;
      if (valid && all_ok) begin
        year_q <= yr_d;
        mon_q  <= b[F_MON] - 7'd1;
        for (int i = 0; i < 4; i++) bin_q[i] <= b[i];
      end
    end
  end

  AST_DEC_YEAR_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (year_q >= YMIN_V && year_q <= YMAX_V)); // R8
  AST_DEC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R6
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(year_q) && $stable(mon_q) && $stable(bin_q))); // R10

endmodule

// File: rtl/cal_bcd_codec.sv
module cal_bcd_codec
  import cal_bcd_pkg::*;
#(
  parameter int YEAR_W       = 12,
  parameter int YEAR_LO      = 1970,
  parameter int BASE_CENTURY = 1900
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid,
  input  logic [YEAR_W-1:0] year_in,
  input  logic [3:0]        month_in,
  input  logic [4:0]        day_in,
  input  logic [4:0]        hour_in,
  input  logic [5:0]        min_in,
  input  logic [5:0]        sec_in,
  output logic              enc_done,
  output logic              enc_err,
  output logic [7:0]        bcd_year,
  output logic [7:0]        bcd_mon,
  output logic [7:0]        bcd_day,
  output logic [7:0]        bcd_hour,
  output logic [7:0]        bcd_min,
  output logic [7:0]        bcd_sec,
  input  logic              dec_valid,
  input  logic [7:0]        rb_year,
  input  logic [7:0]        rb_mon,
  input  logic [7:0]        rb_day,
  input  logic [7:0]        rb_hour,
  input  logic [7:0]        rb_min,
  input  logic [7:0]        rb_sec,
  output logic              dec_done,
  output logic              dec_err,
  output logic [7:0]        dec_year,
  output logic [6:0]        dec_mon,
  output logic [6:0]        dec_day,
  output logic [6:0]        dec_hour,
  output logic [6:0]        dec_min,
  output logic [6:0]        dec_sec
);

  localparam int YEAR_HI = YEAR_LO + 99;
  localparam int SPLIT   = YEAR_LO - BASE_CENTURY;

  logic                   date_ok;
  logic [NFIELD-1:0][7:0] enc_q;
  logic [NFIELD-1:0][7:0] dec_raw;
  logic [3:0][6:0]        dec_bin;

  cal_date_check #(.YEAR_W(YEAR_W), .YEAR_LO(YEAR_LO), .YEAR_HI(YEAR_HI)) u_check (
    .year(year_in), .month(month_in), .day(day_in),
    .hour(hour_in), .minute(min_in), .second(sec_in), .ok(date_ok)
  );

  cal_bcd_enc #(.YEAR_W(YEAR_W), .BASE_CENTURY(BASE_CENTURY)) u_enc (
    .clk(clk), .rst(rst), .valid(enc_valid), .ok(date_ok),
    .year(year_in), .month(month_in), .day(day_in),
    .hour(hour_in), .minute(min_in), .second(sec_in),
    .done(enc_done), .err(enc_err), .bcd_q(enc_q)
  );

  assign bcd_year = enc_q[F_YEAR];
  assign bcd_mon  = enc_q[F_MON];
  assign bcd_day  = enc_q[F_DAY];
  assign bcd_hour = enc_q[F_HOUR];
  assign bcd_min  = enc_q[F_MIN];
  assign bcd_sec  = enc_q[F_SEC];

  assign dec_raw = {rb_year, rb_mon, rb_day, rb_hour, rb_min, rb_sec};

  cal_bcd_dec #(.SPLIT(SPLIT)) u_dec (
    .clk(clk), .rst(rst), .valid(dec_valid), .raw(dec_raw),
    .done(dec_done), .err(dec_err), .year_q(dec_year), .mon_q(dec_mon),
    .bin_q(dec_bin)
  );

  assign dec_day  = dec_bin[F_DAY];
  assign dec_hour = dec_bin[F_HOUR];
  assign dec_min  = dec_bin[F_MIN];
  assign dec_sec  = dec_bin[F_SEC];

endmodule

// File: tb/tb_cal_bcd_codec.sv
`timescale 1ns/1ps
module tb_cal_bcd_codec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        enc_valid = 1'b0;
  logic [11:0] year_in = '0;
  logic [3:0]  month_in = '0;
  logic [4:0]  day_in = '0, hour_in = '0;
  logic [5:0]  min_in = '0, sec_in = '0;
  logic        enc_done, enc_err;
  logic [7:0]  bcd_year, bcd_mon, bcd_day, bcd_hour, bcd_min, bcd_sec;
  logic        dec_valid = 1'b0;
  logic [7:0]  rb_year = '0, rb_mon = '0, rb_day = '0, rb_hour = '0, rb_min = '0, rb_sec = '0;
  logic        dec_done, dec_err;
  logic [7:0]  dec_year;
  logic [6:0]  dec_mon, dec_day, dec_hour, dec_min, dec_sec;

  cal_bcd_codec dut (.*);

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  logic [47:0] m_enc = '0;
  logic [42:0] m_dec = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_bcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic bit legal(int y, int m, int d, int h, int mi, int s);
    bit lp;
    int lim;
    lp  = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (m == 2) lim = lp ? 29 : 28;
    else if (m == 4 || m == 6 || m == 9 || m == 11) lim = 30;
    else if (m >= 1 && m <= 12) lim = 31;
    else lim = 0;
    return (y >= 1970) && (y <= 2069) && (d >= 1) && (d <= lim) &&
           (h < 24) && (mi < 60) && (s < 60);
  endfunction

  function automatic logic [63:0] enc_act();
    return 64'({enc_done, enc_err, bcd_year, bcd_mon, bcd_day, bcd_hour, bcd_min, bcd_sec});
  endfunction

  function automatic logic [63:0] dec_act();
    return 64'({dec_done, dec_err, dec_year, dec_mon, dec_day, dec_hour, dec_min, dec_sec});
  endfunction

  task automatic enc_drive(int y, int m, int d, int h, int mi, int s, output bit ok);
    ok = legal(y, m, d, h, mi, s);
    year_in = 12'(y); month_in = 4'(m); day_in = 5'(d);
    hour_in = 5'(h); min_in = 6'(mi); sec_in = 6'(s);
    enc_valid = 1'b1;
    if (ok)
      m_enc = {tb_bcd((y >= 2000) ? y - 2000 : y - 1900), tb_bcd(m), tb_bcd(d),
               tb_bcd(h), tb_bcd(mi), tb_bcd(s)};
  endtask

  task automatic enc_vec(string tag, int y, int m, int d, int h, int mi, int s);
    bit ok;
    enc_drive(y, m, d, h, mi, s, ok);
    @(negedge clk);
    enc_valid = 1'b0;
    chk(ok ? {tag, " R5 accept"} : {tag, " R7 reject-hold"}, enc_act(), 64'({ok, !ok, m_enc}));
  endtask

  task automatic dec_drive(logic [7:0] by, logic [7:0] bm, logic [7:0] bd,
                           logic [7:0] bh, logic [7:0] bmi, logic [7:0] bs, output bit ok);
    logic [7:0] arr [6];
    int v [6];
    arr[0] = by; arr[1] = bm; arr[2] = bd; arr[3] = bh; arr[4] = bmi; arr[5] = bs;
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (arr[i][7:4] > 9 || arr[i][3:0] > 9) ok = 0;
      v[i] = int'(arr[i][7:4]) * 10 + int'(arr[i][3:0]);
    end
    rb_year = by; rb_mon = bm; rb_day = bd; rb_hour = bh; rb_min = bmi; rb_sec = bs;
    dec_valid = 1'b1;
    if (ok)
      m_dec = {8'((v[0] <= 69) ? v[0] + 100 : v[0]), 7'(v[1] - 1), 7'(v[2]),
               7'(v[3]), 7'(v[4]), 7'(v[5])};
  endtask

  task automatic dec_vec(string tag, logic [7:0] by, logic [7:0] bm, logic [7:0] bd,
                         logic [7:0] bh, logic [7:0] bmi, logic [7:0] bs);
    bit ok;
    dec_drive(by, bm, bd, bh, bmi, bs, ok);
    @(negedge clk);
    dec_valid = 1'b0;
    chk(ok ? {tag, " R8 decode"} : {tag, " R10 digit-reject"}, dec_act(), 64'({ok, !ok, m_dec}));
  endtask

  initial begin
    repeat (1500000) @(negedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    bit ok1, ok2;
    logic [7:0] base [6];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset enc", enc_act(), 64'd0);
    chk("R11 reset dec", dec_act(), 64'd0);

    // R2 named leap cases
    enc_vec("R2 2000-02-29", 2000, 2, 29, 0, 0, 0);
    enc_vec("R2 1999-02-29", 1999, 2, 29, 0, 0, 0);
    enc_vec("R2 1996-02-29", 1996, 2, 29, 0, 0, 0);
    enc_vec("R2 2001-02-29", 2001, 2, 29, 0, 0, 0);

    // R1 year window sweep with margins
    for (int y = 1960; y <= 2079; y++) enc_vec("R1 year", y, 6, 15, 12, 34, 56);

    // R6: flags drop with no strobe, outputs hold
    enc_vec("R6 set", 2024, 7, 4, 9, 8, 7);
    @(negedge clk);
    chk("R6 idle enc", enc_act(), 64'({2'b00, m_enc}));

    // R2 R3 full calendar sweep
    for (int y = 1968; y <= 2071; y++)
      for (int m = 0; m <= 13; m++)
        for (int d = 0; d <= 31; d++)
          enc_vec("R2/R3 date", y, m, d, 1, 2, 3);

    // R4 time sweep
    for (int h = 0; h <= 31; h++)
      for (int mi = 0; mi <= 63; mi++)
        enc_vec("R4 time", 2010, 3, 3, h, mi, (h * 7 + mi) % 64);
    for (int s = 0; s <= 63; s++) enc_vec("R4 sec", 1985, 10, 31, 23, 59, s);

    // decode: each byte position over all values
    base[0] = 8'h24; base[1] = 8'h03; base[2] = 8'h15;
    base[3] = 8'h12; base[4] = 8'h30; base[5] = 8'h45;
    dec_vec("R8 base", base[0], base[1], base[2], base[3], base[4], base[5]);
    dec_vec("R8 pivot69", 8'h69, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    dec_vec("R8 pivot70", 8'h70, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    dec_vec("R9 month00", 8'h05, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    for (int p = 0; p < 6; p++)
      for (int v = 0; v < 256; v++) begin
        logic [7:0] a [6];
        for (int k = 0; k < 6; k++) a[k] = base[k];
        a[p] = 8'(v);
        dec_vec((p == 1) ? "R9 month" : "R10 sweep", a[0], a[1], a[2], a[3], a[4], a[5]);
      end
    @(negedge clk);
    chk("R6 idle dec", dec_act(), 64'({2'b00, m_dec}));

    // R6 both paths in the same cycle
    enc_drive(2063, 11, 30, 22, 10, 5, ok1);
    dec_drive(8'h99, 8'h08, 8'h31, 8'h07, 8'h06, 8'h05, ok2);
    @(negedge clk);
    enc_valid = 1'b0;
    dec_valid = 1'b0;
    chk("R6 joint enc", enc_act(), 64'({ok1, !ok1, m_enc}));
    chk("R6 joint dec", dec_act(), 64'({ok2, !ok2, m_dec}));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule